// File: doc/BRIEF.md
# Indexed Byte Store Access Window

This block exposes a byte-wide storage array through a window of four byte offsets. Software first loads a 16-bit pointer, one byte per offset. It then reads or writes the pointed-to byte through a single data offset. After every data write the pointer returns to zero. A read leaves the pointer where it was. The array sits inside the block as a register file, and its depth is a parameter.

Two protection bits guard two fixed 16-byte windows near the bottom of the array. Each bit is inverted by a one-cycle toggle request. While a bit is set, its window is invisible: writes there are dropped and reads return all ones. Two locations near the top of the array are special:
- One location always reads as zero.
- A control location forces some of its bits whenever it is stored.

Top module: `nvram_index_port`

## Requirements
- R1: A write to offset 0 replaces pointer bits 7:0, and a write to offset 1 replaces pointer bits 15:8. Each leaves the other pointer byte unchanged.
- R2: A write to offset 3 stores the data byte at the pointer location. In the next cycle the pointer is zero. This holds even when the store itself is dropped.
- R3: A read of offset 3 returns the byte at the pointer location and does not move the pointer.
- R4: Reads of offsets 0, 1 and 2 return 0xFF.
- R5: While protection bit 0 is set, locations 0x20 to 0x2F are blocked. While protection bit 1 is set, locations 0x30 to 0x3F are blocked. A blocked write changes nothing in the array, and a blocked read returns 0xFF.
- R6: A cycle with `lock_tgl` high inverts the protection bit chosen by `lock_sel` and leaves the other bit as it was.
- R7: Reset clears both protection bits and the pointer.
- R8: Location DEPTH-15 always reads 0x00, and writes to it have no effect.
- R9: A value v written to location DEPTH-8 reads back as (v & 0x5F) | 0x90.
- R10: When the pointer is DEPTH or higher, writes are dropped and reads return 0xFF. In particular, the location the pointer would reach by wrapping around is left unchanged.
- R11: A write to offset 2 changes neither the pointer nor the array.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_sel | input | 1 | Access strobe, one access per cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_off | input | 2 | Offset within the window |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, valid in the cycle of a read |
| lock_tgl | input | 1 | Invert one protection bit |
| lock_sel | input | 1 | Protection bit chosen by the toggle |

## Verification
The embedded properties watch four things on every cycle:
- the pointer byte loads and its clearing after a data write;
- the pointer holding still across reads;
- a toggle inverting exactly one protection bit, and no bit moving without a toggle;
- the forced pattern in the control location after a store to it.

What a read returns can only be shown by the bench's sweeps. This covers the blocked windows under all four protection combinations, the zero location, out-of-range pointers with their wrap aliases, and the dropped offset-2 write. The bench compares every location against an arithmetic model of the array.

// File: rtl/nvram_index_port.sv
module nvram_index_port #(
  parameter int DEPTH = 2048
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       bus_sel,
  input  logic       bus_we,
  input  logic [1:0] bus_off,
  input  logic [7:0] bus_wdata,
  output logic [7:0] bus_rdata,
  input  logic       lock_tgl,
  input  logic       lock_sel
);
  localparam int          IW        = $clog2(DEPTH);
  localparam logic [15:0] ZERO_ADDR = 16'(DEPTH - 15);
  localparam logic [15:0] CTRL_ADDR = 16'(DEPTH - 8);
  localparam logic [IW-1:0] CTRL_IDX = IW'(DEPTH - 8);

  logic [15:0] addr_q;
  logic [1:0]  lock_q;
  logic [7:0]  mem [DEPTH];

  wire          in_range = 32'(addr_q) < DEPTH;
  wire          blocked  = (addr_q[15:4] == 12'h002 && lock_q[0]) ||
                           (addr_q[15:4] == 12'h003 && lock_q[1]);
  wire [IW-1:0] idx      = addr_q[IW-1:0];
  wire          data_wr  = bus_sel && bus_we && bus_off == 2'd3;
  wire          mem_wr   = data_wr && in_range && !blocked && addr_q != ZERO_ADDR;
  wire [7:0]    ctrl_val = (bus_wdata & 8'h5F) | 8'h90;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
      lock_q <= '0;
    end else begin
      if (bus_sel && bus_we) begin
        case (bus_off)
          2'd0:    addr_q[7:0]  <= bus_wdata;
          2'd1:    addr_q[15:8] <= bus_wdata;
          2'd3:    addr_q       <= '0;
          default: ;
        endcase
      end
      if (lock_tgl) lock_q[lock_sel] <= ~lock_q[lock_sel];
    end
  end

  always_ff @(posedge clk) begin
    if (mem_wr) mem[idx] <= (addr_q == CTRL_ADDR) ? ctrl_val : bus_wdata;
  end

  always_comb begin
    bus_rdata = 8'hFF;
    if (bus_off == 2'd3 && in_range && !blocked)
      bus_rdata = (addr_q == ZERO_ADDR) ? 8'h00 : mem[idx];
  end

  p_addr_low_r1: assert property (@(posedge clk) disable iff (!rst_n)
    bus_sel && bus_we && bus_off == 2'd0 |=>
      addr_q[7:0] == $past(bus_wdata) && addr_q[15:8] == $past(addr_q[15:8]));

  p_addr_high_r1: assert property (@(posedge clk) disable iff (!rst_n)
    bus_sel && bus_we && bus_off == 2'd1 |=>
      addr_q[15:8] == $past(bus_wdata) && addr_q[7:0] == $past(addr_q[7:0]));

  p_addr_clear_r2: assert property (@(posedge clk) disable iff (!rst_n)
    data_wr |=> addr_q == 16'h0000);

  p_read_keeps_addr_r3: assert property (@(posedge clk) disable iff (!rst_n)
    bus_sel && !bus_we |=> $stable(addr_q));

  p_toggle_one_r6: assert property (@(posedge clk) disable iff (!rst_n)
    lock_tgl |=> $countones(lock_q ^ $past(lock_q)) == 1);

  p_lock_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !lock_tgl |=> $stable(lock_q));

  p_ctrl_forced_r9: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr && addr_q == CTRL_ADDR |=>
      mem[CTRL_IDX][7] && mem[CTRL_IDX][4] && !mem[CTRL_IDX][5]);
endmodule

// File: tb/nvram_index_port_tb.sv
module nvram_index_port_tb;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH = 256;
  localparam int ZERO_A = DEPTH - 15;
  localparam int CTRL_A = DEPTH - 8;

  logic clk = 0, rst_n = 0;
  logic bus_sel = 0, bus_we = 0, lock_tgl = 0, lock_sel = 0;
  logic [1:0] bus_off = 0;
  logic [7:0] bus_wdata = 0, bus_rdata;

  int total = 0, bad = 0;
  logic [7:0] model [DEPTH];
  logic [1:0] lk = 0;
  logic [7:0] rv;

  always #(CLK_PERIOD/2) clk = ~clk;

  nvram_index_port #(.DEPTH(DEPTH)) u_dut (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
    .bus_off(bus_off), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .lock_tgl(lock_tgl), .lock_sel(lock_sel));

  function automatic logic is_blk(int a);
    return (a >= 'h20 && a <= 'h2F && lk[0]) || (a >= 'h30 && a <= 'h3F && lk[1]);
  endfunction

  function automatic logic [7:0] exp_rd(int a);
    if (a >= DEPTH || is_blk(a)) return 8'hFF;
    if (a == ZERO_A) return 8'h00;
    return model[a];
  endfunction

  task automatic check(string req, logic [7:0] act, logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic wr(logic [1:0] off, logic [7:0] d);
    @(negedge clk);
    bus_sel = 1; bus_we = 1; bus_off = off; bus_wdata = d;
    @(negedge clk);
    bus_sel = 0; bus_we = 0;
  endtask

  task automatic rd(logic [1:0] off, output logic [7:0] d);
    @(negedge clk);
    bus_sel = 1; bus_we = 0; bus_off = off;
    #1 d = bus_rdata;
    @(negedge clk);
    bus_sel = 0;
  endtask

  task automatic set_addr(int a);
    wr(2'd0, 8'(a));
    wr(2'd1, 8'(a >> 8));
  endtask

  task automatic store(int a, logic [7:0] d);
    set_addr(a);
    wr(2'd3, d);
    if (a < DEPTH && !is_blk(a) && a != ZERO_A)
      model[a] = (a == CTRL_A) ? ((d & 8'h5F) | 8'h90) : d;
  endtask

  task automatic load(int a, output logic [7:0] d);
    set_addr(a);
    rd(2'd3, d);
  endtask

  task automatic toggle(logic b);
    @(negedge clk);
    lock_tgl = 1; lock_sel = b;
    @(negedge clk);
    lock_tgl = 0;
    lk[b] = ~lk[b];
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    bad++; total++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;

    // R7: dirty pointer and locks, then reset
    toggle(0); toggle(1); lk = 0;
    wr(2'd1, 8'h01);
    @(negedge clk); rst_n = 0; @(negedge clk); rst_n = 1;
    wr(2'd0, 8'h25);           // high byte must be zero after reset
    wr(2'd3, 8'hAB);           // lock 0 must be clear after reset
    model[8'h25] = 8'hAB;
    load('h25, rv); check("R7 reset clears pointer and locks", rv, 8'hAB);

    // R2: fill whole array, pointer auto clear routes second write to 0
    for (int a = 0; a < DEPTH; a++) store(a, 8'((a * 7 + 3) ^ (a >> 3)));
    store('h44, 8'h5A);
    wr(2'd3, 8'hC3); model[0] = 8'hC3;
    load(0, rv); check("R2 pointer cleared after data write", rv, 8'hC3);
    load('h44, rv); check("R2 stored byte", rv, 8'h5A);

    // R3/R8/R10: full sweep including out-of-range pointers
    for (int a = 0; a < 2 * DEPTH; a++) begin
      load(a, rv);
      check(a == ZERO_A ? "R8 zero location" : (a >= DEPTH ? "R10 out of range read" : "R3 read"),
            rv, exp_rd(a));
    end

    // R3: repeated read keeps pointer; R4 other offsets
    set_addr('h77);
    rd(2'd3, rv); rd(2'd3, rv); check("R3 pointer stable across reads", rv, model['h77]);
    for (int o = 0; o < 3; o++) begin
      rd(2'(o), rv); check("R4 non-data offset reads FF", rv, 8'hFF);
    end
    rd(2'd3, rv); check("R3 pointer stable after other reads", rv, model['h77]);

    // R11: offset 2 write has no effect
    set_addr('h77);
    wr(2'd2, 8'h00);
    rd(2'd3, rv); check("R11 offset 2 ignored", rv, model['h77]);

    // R10: write beyond depth leaves wrapped alias untouched
    store(DEPTH + 5, 8'hEE);
    load(5, rv); check("R10 alias untouched", rv, model[5]);
    load(DEPTH + 5, rv); check("R10 out of range reads FF", rv, 8'hFF);

    // R8: write to zero location
    store(ZERO_A, 8'h5C);
    load(ZERO_A, rv); check("R8 zero location after write", rv, 8'h00);

    // R5/R6: every lock combination over both windows and neighbours
    for (int c = 0; c < 4; c++) begin
      if (lk[0] != c[0]) toggle(0);
      if (lk[1] != c[1]) toggle(1);
      for (int a = 'h18; a < 'h48; a++) store(a, 8'(a + c * 61));
      for (int a = 'h18; a < 'h48; a++) begin
        load(a, rv); check("R5 lock window access", rv, exp_rd(a));
      end
    end
    if (lk[0]) toggle(0);
    if (lk[1]) toggle(1);
    for (int a = 'h18; a < 'h48; a++) begin
      load(a, rv); check("R6 unlocked contents after toggles", rv, exp_rd(a));
    end

    // R2: blocked write still clears pointer
    toggle(0);
    set_addr('h21); wr(2'd3, 8'h11);
    rd(2'd3, rv); check("R2 pointer cleared after blocked write", rv, model[0]);
    toggle(0);

    // R9: every control value
    for (int v = 0; v < 256; v++) begin
      store(CTRL_A, 8'(v));
      load(CTRL_A, rv); check("R9 control forced bits", rv, (8'(v) & 8'h5F) | 8'h90);
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule